// File: doc/BRIEF.md
# USB Device OUT Endpoint Controller

This block keeps the control state of a single USB device OUT endpoint and chooses the handshake returned for every packet that the receive side reports. Software writes one-cycle command strobes that enable the endpoint, request a disable, set or clear NAK, and force the data toggle. For an isochronous endpoint the last of these commands forces the frame parity instead. The current status can be read back on dedicated outputs at any time.

For each packet the receive path presents the token kind (SETUP or OUT), the data PID, the free space in the receive FIFO, the current frame parity and a last-packet flag. One cycle later the block returns ACK, NAK or no handshake, together with a flag that says whether the packet's data is kept. Within the same update it advances the toggle and pulses the SETUP-done, endpoint-disabled and transfer-complete events. Hardware always clears the enable bit no later than the event that ends the endpoint's activity, so software can rely on the event.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset, enable, disable-pending, NAK and expected PID read 0, no handshake is valid, and no event is pulsed.
- R2: cmd_i bit 0, written with cmd_wr_i, sets the enable bit. Writing 0 in that position never clears it.
- R3: cmd_i bit 1 sets disable-pending only if the endpoint is already enabled, and is ignored otherwise. On the following edge, enable and disable-pending both drop and evt_dis_o pulses in the same cycle.
- R4: A non-isochronous OUT packet that arrives while the endpoint is not enabled, or while a disable is pending, gets NAK and its data is not kept.
- R5: cmd_i bit 2 sets NAK and bit 3 clears it. Set wins when both are written together. While NAK is set, OUT packets get NAK even when the FIFO has room.
- R6: A SETUP packet always gets ACK with its data kept. It makes the expected PID DATA1, clears enable and pulses evt_setup_o.
- R7: An OUT packet needs free FIFO space of at least one full packet, as given by mps_code_i: 00 = 64, 01 = 32, 10 = 16, 11 = 8 bytes. With less space it gets NAK.
- R8: On a bulk, interrupt or control OUT packet that passes R4, R5 and R7, the block returns ACK. If pkt_pid_i equals the expected PID, the data is kept and the expected PID flips. Otherwise the data is dropped and the PID holds.
- R9: cmd_i bit 4 forces the expected PID (or parity) to 0 and bit 5 forces it to 1. Bit 5 wins if both are written. A packet-driven update in the same cycle overrides either command.
- R10: On an isochronous endpoint (ep_type_i = 01) an OUT packet gets no handshake (code 00). Its data is kept only when the endpoint is enabled, no disable is pending, NAK is clear, the FIFO has room and frame_odd_i equals the expected parity. A kept packet flips the parity.
- R11: A kept OUT packet flagged with pkt_last_i clears enable, sets NAK and pulses evt_xfer_o.
- R12: Handshake results appear exactly one cycle after pkt_valid_i. The hs_o codes are 01 = ACK, 10 = NAK and 00 = none. With no packet, hs_valid_o, hs_o and data_keep_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command strobe |
| cmd_i | input | 6 | Command bits: 0 enable, 1 disable, 2 set NAK, 3 clear NAK, 4 PID0/even, 5 PID1/odd |
| ep_type_i | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| mps_code_i | input | 2 | Maximum packet size code |
| pkt_valid_i | input | 1 | Packet received this cycle |
| pkt_setup_i | input | 1 | 1 = SETUP, 0 = OUT |
| pkt_pid_i | input | 1 | Data PID of the packet, 0 = DATA0 |
| pkt_last_i | input | 1 | Packet ends the transfer |
| frame_odd_i | input | 1 | Current frame is odd |
| fifo_free_i | input | FREE_W | Free receive FIFO bytes |
| ep_en_o | output | 1 | Enable status |
| dis_pend_o | output | 1 | Disable pending |
| nak_o | output | 1 | NAK status |
| exp_pid_o | output | 1 | Expected data PID or frame parity |
| hs_valid_o | output | 1 | Handshake result valid |
| hs_o | output | 2 | Handshake code |
| data_keep_o | output | 1 | Packet data is kept |
| evt_setup_o | output | 1 | SETUP-done event pulse |
| evt_dis_o | output | 1 | Endpoint-disabled event pulse |
| evt_xfer_o | output | 1 | Transfer-complete event pulse |

## Verification
The bench builds the block with FREE_W = 8, so the free-space input reaches 255. The stimulus spans 0 to 80 bytes, which places values on both sides of each of the four packet-size thresholds (8, 16, 32, 64), including the exact boundary. Directed sequences walk through enable, toggle matches and mismatches, NAK precedence, SETUP override, disable timing and isochronous parity. A long random phase then mixes command and packet collisions in the same cycle across all endpoint types.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_e;

  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_type_e;

  localparam int CMD_W      = 6;
  localparam int CMD_EN     = 0;
  localparam int CMD_DIS    = 1;
  localparam int CMD_SNAK   = 2;
  localparam int CMD_CNAK   = 3;
  localparam int CMD_PID0   = 4;
  localparam int CMD_PID1   = 5;
  localparam int MPS_W      = 7;
  localparam logic [MPS_W-1:0] MPS_MAX = 7'd64;

  function automatic logic [MPS_W-1:0] mps_bytes(input logic [1:0] code);
    return MPS_MAX >> code;
  endfunction

endpackage

// File: rtl/usb_oep_dec.sv
module usb_oep_dec
  import usb_oep_pkg::*;
#(
  parameter int FREE_W = 10
) (
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              nak_i,
  input  logic              pid_i,
  input  logic [1:0]        ep_type_i,
  input  logic [1:0]        mps_code_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_setup_i,
  input  logic              pkt_pid_i,
  input  logic              pkt_last_i,
  input  logic              frame_odd_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  output hs_e               hs_o,
  output logic              keep_o,
  output logic              flip_o,
  output logic              setup_ev_o,
  output logic              xfer_ev_o
);

  localparam int CMP_W = (FREE_W > MPS_W) ? FREE_W : MPS_W;

  logic [CMP_W-1:0] free_ext, need_ext;
  logic             room, blocked, is_iso;

  assign free_ext = CMP_W'(fifo_free_i);
  assign need_ext = CMP_W'(mps_bytes(mps_code_i));
  assign room     = free_ext >= need_ext;
  assign is_iso   = ep_type_i == EP_ISO;
  assign blocked  = !en_i || dis_i || nak_i || !room;

  always_comb begin
    hs_o       = HS_NONE;
    keep_o     = 1'b0;
    flip_o     = 1'b0;
    setup_ev_o = 1'b0;
    if (pkt_valid_i) begin
      if (pkt_setup_i) begin
        hs_o       = HS_ACK;
        keep_o     = 1'b1;
        setup_ev_o = 1'b1;
      end else if (is_iso) begin
        if (!blocked && (frame_odd_i == pid_i)) begin
          keep_o = 1'b1;
          flip_o = 1'b1;
        end
      end else if (blocked) begin
        hs_o = HS_NAK;
      end else begin
        hs_o = HS_ACK;
        if (pkt_pid_i == pid_i) begin
          keep_o = 1'b1;
          flip_o = 1'b1;
        end
      end
    end
  end

  assign xfer_ev_o = flip_o && pkt_last_i;

endmodule

// File: rtl/usb_oep_state.sv
module usb_oep_state
  import usb_oep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             setup_ev_i,
  input  logic             xfer_ev_i,
  output logic             en_o,
  output logic             dis_o,
  output logic             nak_o,
  output logic             dis_done_o
);

  logic en_q, dis_q, nak_q;
  logic hw_clr, set_en, req_dis, set_nak, clr_nak;

  assign set_en  = cmd_wr_i && cmd_i[CMD_EN];
  assign req_dis = cmd_wr_i && cmd_i[CMD_DIS] && en_q;
  assign set_nak = (cmd_wr_i && cmd_i[CMD_SNAK]) || xfer_ev_i;
  assign clr_nak = cmd_wr_i && cmd_i[CMD_CNAK];
  assign hw_clr  = setup_ev_i || xfer_ev_i || dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dis_q <= 1'b0;
      nak_q <= 1'b0;
    end else begin
      en_q <= (en_q || set_en) && !hw_clr;
      if (dis_q)        dis_q <= 1'b0;
      else if (req_dis) dis_q <= 1'b1;
      if (set_nak)      nak_q <= 1'b1;
      else if (clr_nak) nak_q <= 1'b0;
    end
  end

  assign en_o       = en_q;
  assign dis_o      = dis_q;
  assign nak_o      = nak_q;
  assign dis_done_o = dis_q;

  AST_DIS_ONLY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dis_q) |-> $past(en_q)); // R3
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |=> (!dis_q && !en_q)); // R3
  AST_NAK_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[CMD_SNAK] && cmd_i[CMD_CNAK]) |=> nak_q); // R5
  AST_EN_W1S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[CMD_EN] && !setup_ev_i && !xfer_ev_i && !dis_q) |=> en_q); // R2
  AST_XFER_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ev_i |=> (nak_q && !en_q)); // R11

endmodule

// File: rtl/usb_oep_toggle.sv
module usb_oep_toggle
  import usb_oep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             setup_ev_i,
  input  logic             flip_i,
  output logic             pid_o
);

  logic pid_q;
  logic force1, force0;

  assign force1 = cmd_wr_i && cmd_i[CMD_PID1];
  assign force0 = cmd_wr_i && cmd_i[CMD_PID0];

  // packet-driven updates take precedence over software forcing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pid_q <= 1'b0;
    else if (setup_ev_i) pid_q <= 1'b1;
    else if (flip_i)     pid_q <= !pid_q;
    else if (force1)     pid_q <= 1'b1;
    else if (force0)     pid_q <= 1'b0;
  end

  assign pid_o = pid_q;

  AST_SETUP_D1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_ev_i |=> pid_q); // R6
  AST_FORCE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force1 && !setup_ev_i && !flip_i) |=> pid_q); // R9
  AST_FORCE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force0 && !force1 && !setup_ev_i && !flip_i) |=> !pid_q); // R9
  AST_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_i && !setup_ev_i) |=> (pid_q != $past(pid_q))); // R8

endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_oep_pkg::*;
#(
  parameter int FREE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [5:0]        cmd_i,
  input  logic [1:0]        ep_type_i,
  input  logic [1:0]        mps_code_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_setup_i,
  input  logic              pkt_pid_i,
  input  logic              pkt_last_i,
  input  logic              frame_odd_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  output logic              ep_en_o,
  output logic              dis_pend_o,
  output logic              nak_o,
  output logic              exp_pid_o,
  output logic              hs_valid_o,
  output logic [1:0]        hs_o,
  output logic              data_keep_o,
  output logic              evt_setup_o,
  output logic              evt_dis_o,
  output logic              evt_xfer_o
);

  hs_e  hs_d, hs_q;
  logic en, dis, nak, pid;
  logic keep_d, flip, setup_ev, xfer_ev, dis_done;
  logic hs_valid_q, keep_q, evt_setup_q, evt_dis_q, evt_xfer_q;

  usb_oep_dec #(.FREE_W(FREE_W)) u_dec (
    .en_i        (en),
    .dis_i       (dis),
    .nak_i       (nak),
    .pid_i       (pid),
    .ep_type_i   (ep_type_i),
    .mps_code_i  (mps_code_i),
    .pkt_valid_i (pkt_valid_i),
    .pkt_setup_i (pkt_setup_i),
    .pkt_pid_i   (pkt_pid_i),
    .pkt_last_i  (pkt_last_i),
    .frame_odd_i (frame_odd_i),
    .fifo_free_i (fifo_free_i),
    .hs_o        (hs_d),
    .keep_o      (keep_d),
    .flip_o      (flip),
    .setup_ev_o  (setup_ev),
    .xfer_ev_o   (xfer_ev)
  );

  usb_oep_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .setup_ev_i (setup_ev),
    .xfer_ev_i  (xfer_ev),
    .en_o       (en),
    .dis_o      (dis),
    .nak_o      (nak),
    .dis_done_o (dis_done)
  );

  usb_oep_toggle u_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_i      (cmd_i),
    .setup_ev_i (setup_ev),
    .flip_i     (flip),
    .pid_o      (pid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_q  <= 1'b0;
      hs_q        <= HS_NONE;
      keep_q      <= 1'b0;
      evt_setup_q <= 1'b0;
      evt_dis_q   <= 1'b0;
      evt_xfer_q  <= 1'b0;
    end else begin
      hs_valid_q  <= pkt_valid_i;
      hs_q        <= hs_d;
      keep_q      <= keep_d;
      evt_setup_q <= setup_ev;
      evt_dis_q   <= dis_done;
      evt_xfer_q  <= xfer_ev;
    end
  end

  assign ep_en_o     = en;
  assign dis_pend_o  = dis;
  assign nak_o       = nak;
  assign exp_pid_o   = pid;
  assign hs_valid_o  = hs_valid_q;
  assign hs_o        = hs_q;
  assign data_keep_o = keep_q;
  assign evt_setup_o = evt_setup_q;
  assign evt_dis_o   = evt_dis_q;
  assign evt_xfer_o  = evt_xfer_q;

  AST_SETUP_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_setup_i) |=> (hs_valid_o && hs_o == HS_ACK && data_keep_o)); // R6
  AST_NAK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_setup_i && ep_type_i != EP_ISO && nak_o)
    |=> (hs_o == HS_NAK && !data_keep_o)); // R5
  AST_ISO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_setup_i && ep_type_i == EP_ISO) |=> (hs_o == HS_NONE)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_valid_o |-> (hs_o == HS_NONE && !data_keep_o)); // R12
  AST_DIS_EVT_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_dis_o |-> (!ep_en_o && !dis_pend_o)); // R3
  AST_EVT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_setup_o, evt_xfer_o})); // R11

endmodule

// File: tb/usb_out_ep_ctrl_tb.sv
module usb_out_ep_ctrl_tb_top;

  localparam int FREE_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_wr_i = 1'b0;
  logic [5:0]        cmd_i = '0;
  logic [1:0]        ep_type_i = 2'b10;
  logic [1:0]        mps_code_i = 2'b00;
  logic              pkt_valid_i = 1'b0;
  logic              pkt_setup_i = 1'b0;
  logic              pkt_pid_i = 1'b0;
  logic              pkt_last_i = 1'b0;
  logic              frame_odd_i = 1'b0;
  logic [FREE_W-1:0] fifo_free_i = '0;
  logic ep_en_o, dis_pend_o, nak_o, exp_pid_o, hs_valid_o, data_keep_o;
  logic evt_setup_o, evt_dis_o, evt_xfer_o;
  logic [1:0] hs_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  usb_out_ep_ctrl #(.FREE_W(FREE_W)) dut_i (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_i, .ep_type_i, .mps_code_i,
    .pkt_valid_i, .pkt_setup_i, .pkt_pid_i, .pkt_last_i, .frame_odd_i,
    .fifo_free_i, .ep_en_o, .dis_pend_o, .nak_o, .exp_pid_o, .hs_valid_o,
    .hs_o, .data_keep_o, .evt_setup_o, .evt_dis_o, .evt_xfer_o
  );

  // reference model state and expected outputs
  bit m_en, m_dis, m_nak, m_pid, m_hsv, m_keep, m_es, m_ed, m_ex;
  int m_hs;
  string m_tag_hs, m_tag_keep;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_dis = 0; m_nak = 0; m_pid = 0; m_hsv = 0;
      m_keep = 0; m_es = 0; m_ed = 0; m_ex = 0; m_hs = 0;
      m_tag_hs = "R1"; m_tag_keep = "R1";
    end else begin
      bit iso, room, flip, setup, xfer, done_dis, n_en, n_dis, n_nak, n_pid;
      int need;
      int hs;
      bit keep;
      iso = (ep_type_i == 2'b01);
      need = 64 >> mps_code_i;
      room = int'(fifo_free_i) >= need;
      hs = 0; keep = 0; flip = 0; setup = 0;
      m_tag_hs = "R12"; m_tag_keep = "R12";
      if (pkt_valid_i) begin
        if (pkt_setup_i) begin
          hs = 1; keep = 1; setup = 1;
          m_tag_hs = "R6"; m_tag_keep = "R6";
        end else if (iso) begin
          m_tag_hs = "R10"; m_tag_keep = "R10";
          if (m_en && !m_dis && !m_nak && room && frame_odd_i == m_pid) begin
            keep = 1; flip = 1;
          end
        end else if (!m_en || m_dis) begin
          hs = 2; m_tag_hs = "R4"; m_tag_keep = "R4";
        end else if (m_nak) begin
          hs = 2; m_tag_hs = "R5"; m_tag_keep = "R5";
        end else if (!room) begin
          hs = 2; m_tag_hs = "R7"; m_tag_keep = "R7";
        end else begin
          hs = 1; m_tag_hs = "R8"; m_tag_keep = "R8";
          if (pkt_pid_i == m_pid) begin keep = 1; flip = 1; end
        end
      end
      xfer = flip && pkt_last_i;
      done_dis = m_dis;
      n_en = (m_en || (cmd_wr_i && cmd_i[0])) && !(setup || xfer || done_dis);
      n_dis = done_dis ? 1'b0 : (m_dis || (cmd_wr_i && cmd_i[1] && m_en));
      n_nak = ((cmd_wr_i && cmd_i[2]) || xfer) ? 1'b1 :
              (cmd_wr_i && cmd_i[3]) ? 1'b0 : m_nak;
      n_pid = setup ? 1'b1 : flip ? !m_pid : (cmd_wr_i && cmd_i[5]) ? 1'b1 :
              (cmd_wr_i && cmd_i[4]) ? 1'b0 : m_pid;
      m_en = n_en; m_dis = n_dis; m_nak = n_nak; m_pid = n_pid;
      m_hsv = pkt_valid_i; m_hs = hs; m_keep = keep;
      m_es = setup; m_ed = done_dis; m_ex = xfer;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      vectors++;
      chk("R2",  int'(ep_en_o),     int'(m_en),   "ep_en");
      chk("R3",  int'(dis_pend_o),  int'(m_dis),  "dis_pend");
      chk("R5",  int'(nak_o),       int'(m_nak),  "nak");
      chk("R9",  int'(exp_pid_o),   int'(m_pid),  "exp_pid");
      chk("R12", int'(hs_valid_o),  int'(m_hsv),  "hs_valid");
      chk(m_tag_hs,   int'(hs_o),        m_hs,         "hs");
      chk(m_tag_keep, int'(data_keep_o), int'(m_keep), "keep");
      chk("R6",  int'(evt_setup_o), int'(m_es),   "evt_setup");
      chk("R3",  int'(evt_dis_o),   int'(m_ed),   "evt_dis");
      chk("R11", int'(evt_xfer_o),  int'(m_ex),   "evt_xfer");
    end
  end

  task automatic idle();
    @(negedge clk_i);
    cmd_wr_i = 0; cmd_i = '0; pkt_valid_i = 0; pkt_setup_i = 0;
    pkt_pid_i = 0; pkt_last_i = 0;
  endtask

  task automatic cmd(input logic [5:0] c);
    @(negedge clk_i);
    pkt_valid_i = 0; cmd_wr_i = 1; cmd_i = c;
  endtask

  task automatic pkt(input bit setup, input bit pid, input bit last, input int free);
    @(negedge clk_i);
    cmd_wr_i = 0; cmd_i = '0;
    pkt_valid_i = 1; pkt_setup_i = setup; pkt_pid_i = pid;
    pkt_last_i = last; fifo_free_i = FREE_W'(free);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: reset state
    vectors++;
    chk("R1", int'({ep_en_o, dis_pend_o, nak_o, exp_pid_o, hs_valid_o}), 0, "status");
    // R4: packet before enable
    pkt(0, 0, 0, 64); idle();
    // R2: enable, write of zero keeps it
    cmd(6'b000001); cmd(6'b000000); idle();
    // R8: match then mismatch
    pkt(0, 0, 0, 64); pkt(0, 0, 0, 64); pkt(0, 1, 0, 64); idle();
    // R7: room boundaries for each code
    for (int c = 0; c < 4; c++) begin
      mps_code_i = 2'(c);
      pkt(0, exp_pid_o, 0, (64 >> c) - 1);
      pkt(0, exp_pid_o, 0, 64 >> c);
    end
    idle(); mps_code_i = 2'b00;
    // R5: NAK overrides room, set wins
    cmd(6'b000100); pkt(0, exp_pid_o, 0, 200);
    cmd(6'b001100); cmd(6'b001000); pkt(0, exp_pid_o, 0, 200);
    // R9: force toggle, DATA1 wins
    cmd(6'b010000); cmd(6'b110000); cmd(6'b010000); idle();
    // R11: last packet
    pkt(0, exp_pid_o, 1, 100); idle();
    cmd(6'b001001); idle();
    // R6: SETUP while NAK and with no room
    cmd(6'b000100); pkt(1, 0, 0, 0); idle();
    // R3: disable ignored when off, honoured when on
    cmd(6'b000010); idle(); cmd(6'b001001); cmd(6'b000010);
    pkt(0, exp_pid_o, 0, 64); idle(); idle();
    // R10: isochronous parity
    ep_type_i = 2'b01; cmd(6'b000001); cmd(6'b010000);
    frame_odd_i = 1; pkt(0, 0, 0, 64);
    frame_odd_i = 0; pkt(0, 0, 0, 64);
    frame_odd_i = 1; pkt(0, 0, 0, 64); cmd(6'b100000);
    frame_odd_i = 1; pkt(0, 0, 1, 64); idle();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      ep_type_i   = 2'($urandom);
      mps_code_i  = 2'($urandom);
      frame_odd_i = 1'($urandom);
      fifo_free_i = FREE_W'($urandom_range(0, 80));
      cmd_wr_i    = ($urandom_range(0, 3) == 0);
      cmd_i       = 6'($urandom) & ($urandom_range(0, 1) ? 6'b111111 : 6'b001101);
      pkt_valid_i = ($urandom_range(0, 1) == 0);
      pkt_setup_i = ($urandom_range(0, 9) == 0);
      pkt_pid_i   = ($urandom_range(0, 2) == 0) ? !exp_pid_o : exp_pid_o;
      pkt_last_i  = ($urandom_range(0, 7) == 0);
    end
    idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule